// File: doc/BRIEF.md
# Lazy Condition Code Evaluator

This combinational block rebuilds the four arithmetic condition flags (negative, zero, overflow, carry) long after the operation that produced them has retired. The datapath records only a kind code, the result and one source operand. When a branch or flag read needs the flags, those three values are fed in and the block recovers the missing operand by arithmetic. It then derives the flags with the rule for that kind, at 32-bit width or truncated to a byte or a halfword for the narrow compare kinds.

A second path runs the extended add and extended subtract operations, which take the incoming extend bit as a carry or borrow. This path produces the 32-bit result and the new extend bit. Its flags come from the same evaluator, and the zero flag is treated as sticky across a multi-word chain: the zero flag can only be cleared, never set. The path is selected with `ext_en_i`. Flag vectors on the ports use bit 0 = C, bit 1 = V, bit 2 = Z, bit 3 = N.

Top module: `lazy_cc_unit`

## Requirements
- R1: With `ext_en_i`=0 and kind 0 (precomputed), `flags_o` equals `a_i[3:0]` unchanged.
- R2: Kind 1 (logic) sets Z when `a_i` is zero and N when `a_i[31]` is one; V and C are 0.
- R3: Kind 2 (add, `a_i`=sum, `b_i`=addend) sets C when `a_i` < `b_i` unsigned. It sets V when the rebuilt first operand (`a_i`-`b_i`) and `b_i` have equal signs and the sign of `a_i` differs from them. N and Z come from `a_i`.
- R4: Kind 3 (subtract, `a_i`=difference, `b_i`=subtrahend) rebuilds the minuend as `a_i`+`b_i`. It sets C when the minuend < `b_i` unsigned, and sets V when the minuend's sign differs from both `b_i` and `a_i`.
- R5: Kinds 4 (byte compare) and 5 (halfword compare) apply the R4 rule to bits [7:0] or [15:0] only. N is taken from bit 7 or bit 15, and the upper bits are ignored.
- R6: Kind 6 (add with extend) sets C when `a_i` <= `b_i` unsigned, with V checked against the rebuilt operand `a_i`-`b_i`-1.
- R7: Kind 8 (subtract with extend) rebuilds the minuend as `a_i`+`b_i`+1 and sets C when it is <= `b_i`; V follows the R4 sign rule with that minuend.
- R8: Kind 7 (shift) sets N and Z from `a_i`, C when `b_i` is nonzero, and V to 0.
- R9: With `ext_en_i`=1 and kind 6 or 8, `result_o` is `a_i`+`b_i`+`x_i` or `a_i`-`b_i`-`x_i`. `x_o` is `a_i`<=`b_i` (subtract) or `result_o`<=`b_i` (add) when `x_i`=1, and uses a strict < when `x_i`=0. `flags_o` C equals `x_o`.
- R10: On the extended path, Z out is the AND of the newly evaluated Z and `flags_i[2]`; N, V and C do not depend on `flags_i`.
- R11: Kind codes 9 to 15, or `ext_en_i`=1 with a kind other than 6 or 8, raise `err_o` and drive `flags_o` to 0; otherwise `err_o` is 0.
- R12: Outside a valid extended operation, `result_o` equals `a_i` and `x_o` equals `x_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_en_i | input | 1 | Select extended add/subtract path |
| kind_i | input | 4 | Recorded operation kind code |
| a_i | input | 32 | Saved result, or first operand on the extended path |
| b_i | input | 32 | Saved operand, or second operand on the extended path |
| x_i | input | 1 | Incoming extend bit |
| flags_i | input | 4 | Previous flags (only Z is used) |
| result_o | output | 32 | Extended result or pass-through of `a_i` |
| flags_o | output | 4 | Rebuilt flags {N,Z,V,C} |
| x_o | output | 1 | New extend bit |
| err_o | output | 1 | Unrecognised kind |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle the inputs settle. An operand-rebuild error shows as V or C wrong only for operands near a sign or wrap boundary, which is why the vectors sit on 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. A narrow-compare truncation fault appears only when the upper bits disagree with the low byte or halfword. A sticky-Z fault appears only when an extended operation produces zero while the previous Z is clear.

// File: rtl/lazy_cc_pkg.sv
package lazy_cc_pkg;
  localparam int FLAG_W = 4;
  localparam int FL_C = 0;
  localparam int FL_V = 1;
  localparam int FL_Z = 2;
  localparam int FL_N = 3;

  typedef enum logic [3:0] {
    CK_FLAGS = 4'd0,
    CK_LOGIC = 4'd1,
    CK_ADD   = 4'd2,
    CK_SUB   = 4'd3,
    CK_CMPB  = 4'd4,
    CK_CMPW  = 4'd5,
    CK_ADDX  = 4'd6,
    CK_SHIFT = 4'd7,
    CK_SUBX  = 4'd8
  } cc_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;
endpackage

// File: rtl/cc_sub_flags.sv
module cc_sub_flags
  import lazy_cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] diff_i,
  input  logic [W-1:0] subtr_i,
  output cc_flags_t    flags_o
);
  logic [W-1:0] minuend;
  assign minuend   = diff_i + subtr_i;
  assign flags_o.n = diff_i[W-1];
  assign flags_o.z = (diff_i == '0);
  assign flags_o.c = (minuend < subtr_i);
  assign flags_o.v = (minuend[W-1] ^ diff_i[W-1]) & (minuend[W-1] ^ subtr_i[W-1]);
endmodule

// File: rtl/cc_flag_eval.sv
module cc_flag_eval
  import lazy_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        kind_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] opnd_i,
  output cc_flags_t         flags_o,
  output logic              err_o
);
  localparam int NUM_SUB = 3;  // full, half, quarter width

  cc_flags_t sub_f [NUM_SUB];

  for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
    localparam int SW = DATA_W >> g;
    cc_sub_flags #(.W(SW)) u_sub (
      .diff_i  (res_i[SW-1:0]),
      .subtr_i (opnd_i[SW-1:0]),
      .flags_o (sub_f[g])
    );
  end

  logic              res_n, res_z;
  logic [DATA_W-1:0] orig_add, orig_addx, mnd_subx;

  assign res_n     = res_i[DATA_W-1];
  assign res_z     = (res_i == '0);
  assign orig_add  = res_i - opnd_i;
  assign orig_addx = res_i - opnd_i - 1'b1;
  assign mnd_subx  = res_i + opnd_i + 1'b1;

  always_comb begin
    flags_o = '0;
    err_o   = 1'b0;
    case (kind_i)
      CK_FLAGS: flags_o = res_i[FLAG_W-1:0];
      CK_LOGIC: begin
        flags_o.n = res_n;
        flags_o.z = res_z;
      end
      CK_ADD: begin
        flags_o.n = res_n;
        flags_o.z = res_z;
        flags_o.c = (res_i < opnd_i);
        flags_o.v = (opnd_i[DATA_W-1] ^ res_i[DATA_W-1]) &
                    ~(orig_add[DATA_W-1] ^ opnd_i[DATA_W-1]);
      end
      CK_SUB:  flags_o = sub_f[0];
      CK_CMPW: flags_o = sub_f[1];
      CK_CMPB: flags_o = sub_f[2];
      CK_ADDX: begin
        flags_o.n = res_n;
        flags_o.z = res_z;
        flags_o.c = (res_i <= opnd_i);
        flags_o.v = (opnd_i[DATA_W-1] ^ res_i[DATA_W-1]) &
                    ~(orig_addx[DATA_W-1] ^ opnd_i[DATA_W-1]);
      end
      CK_SUBX: begin
        flags_o.n = res_n;
        flags_o.z = res_z;
        flags_o.c = (mnd_subx <= opnd_i);
        flags_o.v = (mnd_subx[DATA_W-1] ^ res_i[DATA_W-1]) &
                    (mnd_subx[DATA_W-1] ^ opnd_i[DATA_W-1]);
      end
      CK_SHIFT: begin
        flags_o.n = res_n;
        flags_o.z = res_z;
        flags_o.c = (opnd_i != '0);
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cc_ext_alu.sv
module cc_ext_alu
  import lazy_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op1_i,
  input  logic [DATA_W-1:0] op2_i,
  input  logic              x_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              x_o,
  output logic [3:0]        kind_o
);
  logic [DATA_W-1:0] sum, diff;

  assign sum  = op1_i + op2_i + {{(DATA_W-1){1'b0}}, x_i};
  assign diff = op1_i - op2_i - {{(DATA_W-1){1'b0}}, x_i};

  always_comb begin
    if (sub_i) begin
      res_o  = diff;
      x_o    = x_i ? (op1_i <= op2_i) : (op1_i < op2_i);
      kind_o = x_i ? CK_SUBX : CK_SUB;
    end else begin
      res_o  = sum;
      x_o    = x_i ? (sum <= op2_i) : (sum < op2_i);
      kind_o = x_i ? CK_ADDX : CK_ADD;
    end
  end
endmodule

// File: rtl/lazy_cc_unit.sv
module lazy_cc_unit
  import lazy_cc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              ext_en_i,
  input  logic [3:0]        kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              x_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        flags_o,
  output logic              x_o,
  output logic              err_o
);
  logic              ext_ok, ext_sub;
  logic [DATA_W-1:0] alu_res, ev_res;
  logic              alu_x, ev_err;
  logic [3:0]        alu_kind, ev_kind;
  cc_flags_t         ev_flags, out_flags;

  assign ext_sub = (kind_i == CK_SUBX);
  assign ext_ok  = ext_en_i & ((kind_i == CK_ADDX) | ext_sub);

  cc_ext_alu #(.DATA_W(DATA_W)) u_alu (
    .op1_i  (a_i),
    .op2_i  (b_i),
    .x_i    (x_i),
    .sub_i  (ext_sub),
    .res_o  (alu_res),
    .x_o    (alu_x),
    .kind_o (alu_kind)
  );

  assign ev_kind = ext_ok ? alu_kind : kind_i;
  assign ev_res  = ext_ok ? alu_res  : a_i;

  cc_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .kind_i  (ev_kind),
    .res_i   (ev_res),
    .opnd_i  (b_i),
    .flags_o (ev_flags),
    .err_o   (ev_err)
  );

  always_comb begin
    out_flags = ev_flags;
    if (ext_ok) out_flags.z = ev_flags.z & flags_i[FL_Z];  // Z only clears
  end

  assign err_o    = ext_en_i ? ~ext_ok : ev_err;
  assign flags_o  = err_o ? '0 : out_flags;
  assign result_o = ext_ok ? alu_res : a_i;
  assign x_o      = ext_ok ? alu_x : x_i;

  always_comb begin
    if (ext_ok)
      assert_x_tracks_c_R9: assert (x_o == flags_o[FL_C]);
    if (ext_ok && !flags_i[FL_Z])
      assert_z_sticky_R10: assert (!flags_o[FL_Z]);
    if (!ext_en_i && kind_i > CK_SUBX)
      assert_bad_kind_R11: assert (err_o && flags_o == '0);
    if (!ext_en_i && kind_i == CK_LOGIC)
      assert_logic_vc_R2: assert (flags_o[FL_V] == 1'b0 && flags_o[FL_C] == 1'b0);
    if (!ext_en_i && kind_i == CK_CMPB)
      assert_cmpb_sign_R5: assert (flags_o[FL_N] == a_i[7]);
    if (!ext_en_i && kind_i == CK_SHIFT)
      assert_shift_nz_R8: assert (!(flags_o[FL_N] && flags_o[FL_Z]));
  end
endmodule

// File: tb/lazy_cc_unit_bench.sv
module lazy_cc_unit_bench;
  logic        clk = 1'b0;
  logic        ext_en;
  logic [3:0]  kind;
  logic [31:0] a, b;
  logic        x;
  logic [3:0]  fl_in;
  logic [31:0] result;
  logic [3:0]  flags;
  logic        x_out, err;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  lazy_cc_unit u_lazy_cc_unit (
    .ext_en_i (ext_en),
    .kind_i   (kind),
    .a_i      (a),
    .b_i      (b),
    .x_i      (x),
    .flags_i  (fl_in),
    .result_o (result),
    .flags_o  (flags),
    .x_o      (x_out),
    .err_o    (err)
  );

  task automatic drive(input logic e, input logic [3:0] k, input logic [31:0] av,
                       input logic [31:0] bv, input logic xv, input logic [3:0] fv);
    @(posedge clk);
    ext_en = e; kind = k; a = av; b = bv; x = xv; fl_in = fv;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic t_reset_state;
    drive(1'b0, 4'd1, 32'h0, 32'h0, 1'b0, 4'h0);
    chk("R2 idle zero", {28'h0, flags}, 32'h4);
    chk("R11 idle no err", {31'h0, err}, 32'h0);
  endtask

  task automatic t_precomputed;
    drive(1'b0, 4'd0, 32'hABCD_0005, 32'hFFFF_FFFF, 1'b0, 4'h0);
    chk("R1 pass 5", {28'h0, flags}, 32'h5);
    drive(1'b0, 4'd0, 32'h0000_00FA, 32'h0, 1'b1, 4'hF);
    chk("R1 pass A", {28'h0, flags}, 32'hA);
  endtask

  task automatic t_logic;
    drive(1'b0, 4'd1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 4'h0);
    chk("R2 neg", {28'h0, flags}, 32'h8);
    drive(1'b0, 4'd1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 4'hF);
    chk("R2 pos", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_add;
    drive(1'b0, 4'd2, 32'h8000_0000, 32'h1, 1'b0, 4'h0);
    chk("R3 overflow", {28'h0, flags}, 32'hA);
    drive(1'b0, 4'd2, 32'h0, 32'h1, 1'b0, 4'h0);
    chk("R3 wrap", {28'h0, flags}, 32'h5);
  endtask

  task automatic t_sub;
    drive(1'b0, 4'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h0);
    chk("R4 borrow", {28'h0, flags}, 32'h9);
    drive(1'b0, 4'd3, 32'h7FFF_FFFF, 32'h1, 1'b0, 4'h0);
    chk("R4 overflow", {28'h0, flags}, 32'h2);
    drive(1'b0, 4'd3, 32'h0, 32'h5, 1'b0, 4'h0);
    chk("R4 equal", {28'h0, flags}, 32'h4);
  endtask

  task automatic t_narrow;
    drive(1'b0, 4'd4, 32'h0000_1280, 32'hFFFF_FF01, 1'b0, 4'h0);
    chk("R5 byte neg", {28'h0, flags}, 32'h8);
    drive(1'b0, 4'd4, 32'hFFFF_FF00, 32'h0, 1'b0, 4'h0);
    chk("R5 byte zero", {28'h0, flags}, 32'h4);
    drive(1'b0, 4'd5, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 4'h0);
    chk("R5 half borrow", {28'h0, flags}, 32'h9);
    drive(1'b0, 4'd5, 32'h1234_7FFF, 32'h0000_0001, 1'b0, 4'h0);
    chk("R5 half ovf", {28'h0, flags}, 32'h2);
  endtask

  task automatic t_ext_eval;
    drive(1'b0, 4'd6, 32'h5, 32'h5, 1'b0, 4'h0);
    chk("R6 equal carry", {28'h0, flags}, 32'h1);
    drive(1'b0, 4'd6, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'h0);
    chk("R6 zero", {28'h0, flags}, 32'h5);
    drive(1'b0, 4'd8, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'h0);
    chk("R7 borrow", {28'h0, flags}, 32'h9);
    drive(1'b0, 4'd8, 32'h7FFF_FFFF, 32'h0, 1'b0, 4'h0);
    chk("R7 overflow", {28'h0, flags}, 32'h2);
  endtask

  task automatic t_shift;
    drive(1'b0, 4'd7, 32'h0, 32'h1, 1'b0, 4'h0);
    chk("R8 zero carry", {28'h0, flags}, 32'h5);
    drive(1'b0, 4'd7, 32'h8000_0000, 32'h0, 1'b0, 4'h0);
    chk("R8 neg", {28'h0, flags}, 32'h8);
  endtask

  task automatic t_bad_kind;
    drive(1'b0, 4'd9, 32'h0, 32'h0, 1'b0, 4'h0);
    chk("R11 kind9 err", {31'h0, err}, 32'h1);
    chk("R11 kind9 flags", {28'h0, flags}, 32'h0);
    drive(1'b0, 4'd15, 32'h8000_0000, 32'h0, 1'b0, 4'h0);
    chk("R11 kind15 err", {31'h0, err}, 32'h1);
    drive(1'b1, 4'd2, 32'h0, 32'h1, 1'b0, 4'h4);
    chk("R11 ext bad err", {31'h0, err}, 32'h1);
    chk("R11 ext bad flags", {28'h0, flags}, 32'h0);
  endtask

  task automatic t_pass;
    drive(1'b0, 4'd3, 32'h1357_9BDF, 32'h5, 1'b1, 4'h0);
    chk("R12 result", result, 32'h1357_9BDF);
    chk("R12 x high", {31'h0, x_out}, 32'h1);
    drive(1'b0, 4'd3, 32'h2468_ACE0, 32'h5, 1'b0, 4'hF);
    chk("R12 x low", {31'h0, x_out}, 32'h0);
  endtask

  task automatic t_ext_path;
    drive(1'b1, 4'd8, 32'h3, 32'h5, 1'b0, 4'h4);
    chk("R9 sub res", result, 32'hFFFF_FFFE);
    chk("R9 sub x", {31'h0, x_out}, 32'h1);
    chk("R9 sub flags", {28'h0, flags}, 32'h9);
    drive(1'b1, 4'd8, 32'h5, 32'h5, 1'b1, 4'h4);
    chk("R9 subx res", result, 32'hFFFF_FFFF);
    chk("R9 subx x", {31'h0, x_out}, 32'h1);
    chk("R9 subx flags", {28'h0, flags}, 32'h9);
    drive(1'b1, 4'd8, 32'h6, 32'h5, 1'b1, 4'h4);
    chk("R10 subx zero kept", {28'h0, flags}, 32'h4);
    chk("R9 subx x clear", {31'h0, x_out}, 32'h0);
    drive(1'b1, 4'd8, 32'h6, 32'h5, 1'b1, 4'hB);
    chk("R10 subx zero not set", {28'h0, flags}, 32'h0);
    drive(1'b1, 4'd6, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h4);
    chk("R9 add res", result, 32'h0);
    chk("R9 add x", {31'h0, x_out}, 32'h1);
    chk("R10 add z kept", {28'h0, flags}, 32'h5);
    drive(1'b1, 4'd6, 32'hFFFF_FFFF, 32'h1, 1'b0, 4'h0);
    chk("R10 add z not set", {28'h0, flags}, 32'h1);
    drive(1'b1, 4'd6, 32'h7FFF_FFFF, 32'h0, 1'b1, 4'h4);
    chk("R9 addx res", result, 32'h8000_0000);
    chk("R9 addx x", {31'h0, x_out}, 32'h0);
    chk("R10 addx z cleared", {28'h0, flags}, 32'hA);
    drive(1'b1, 4'd6, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'h4);
    chk("R9 addx wrap x", {31'h0, x_out}, 32'h1);
    chk("R9 addx wrap flags", {28'h0, flags}, 32'h5);
  endtask

  initial begin
    ext_en = 1'b0; kind = 4'd0; a = '0; b = '0; x = 1'b0; fl_in = 4'h0;
    t_reset_state();
    t_precomputed();
    t_logic();
    t_add();
    t_sub();
    t_narrow();
    t_ext_eval();
    t_shift();
    t_bad_kind();
    t_pass();
    t_ext_path();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule